// File: doc/BRIEF.md
# Dual-Bank Programmable Interrupt Controller

This block gathers up to 32 asynchronous interrupt lines and presents them to a processor through two independent banks. The normal bank drives `irq_o` and the fast bank drives `fiq_o`. Each bank holds its own enable mask, a trigger-kind select, a polarity select and a write-one-to-clear acknowledge port. Each bank can be read back as a raw pending view and as a masked status view.

Every line first passes through a multi-flop synchroniser. In level mode, a line's pending bit follows the synchronised input after the polarity is applied. In edge mode, a qualifying transition sets a sticky latch, and the latch holds until software writes a one to that line's bit in the clear register. The processor reads the status register, services the lowest set bit, acknowledges it, and repeats until status reads zero.

The register port is a single-cycle bus. A write takes effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `dual_bank_intc`

## Requirements
- R1: Address bit 5 selects the bank (0 = normal, 1 = fast). Address bits 4:2 select the register: 0x00 raw pending, 0x04 mask, 0x08 clear, 0x0C mode, 0x10 polarity, 0x14 status. Mask, mode and polarity read back as written. Clear reads as zero. Bit n of every register belongs to line n.
- R2: With mode bit 0 (level), the pending bit equals the input XOR the polarity bit: polarity 0 is active-high and polarity 1 is active-low. The raw view shows the change two clocks after the input changes.
- R3: With mode bit 1 (edge), a rising edge (polarity 0) or a falling edge (polarity 1) of the synchronised input sets a pending bit. That bit stays set after the input returns to its idle level.
- R4: Writing 1 to a clear bit removes that line's edge-pending bit. Clear bits written as 0 change nothing. A new edge that lands in the same cycle as the clear leaves the bit pending.
- R5: A write to the clear register has no lasting effect on a level-mode line.
- R6: Status equals raw pending AND mask. A mask bit of 1 enables its line.
- R7: Each bank output is the OR of that bank's status bits, registered once.
- R8: A loop that acknowledges the lowest set status bit until status reads zero ends after as many iterations as there were pending edge lines. It visits the lines in ascending order.
- R9: The two banks are independent. A write to one bank leaves the other bank's registers and output unchanged.
- R10: After reset, all mask, mode, polarity and pending state is zero, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| line_in | input | 32 | Asynchronous interrupt lines |
| irq_o | output | 1 | Normal bank interrupt request |
| fiq_o | output | 1 | Fast bank interrupt request |

## Verification
A stuck or lost edge latch shows in the raw view three clocks after the input edge. It also shows one clock later on the bank output, and it persists until a clear is written, so a walking-one sweep over every line exposes any single bad bit. A clear that wrongly overrides a coincident edge leaves the raw bit at zero in the cycle after the write. A mis-decoded bank or register address shows up as a wrong readback, or as a change on the other bank's output, on the very next read.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int ADDR_W = 6;
   typedef enum logic [2:0] {
      RG_RAW   = 3'd0,
      RG_MASK  = 3'd1,
      RG_CLEAR = 3'd2,
      RG_MODE  = 3'd3,
      RG_POL   = 3'd4,
      RG_STAT  = 3'd5
   } intc_reg_e;
   localparam int N_BANKS = 2;
endpackage

// File: rtl/intc_line_sync.sv
module intc_line_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter int NLINES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] sync_i,
   input  logic              wr_i,
   input  intc_reg_e         sel_i,
   input  logic [NLINES-1:0] wdata_i,
   output logic [NLINES-1:0] rdata_o,
   output logic [NLINES-1:0] stat_o,
   output logic [NLINES-1:0] pend_o,
   output logic [NLINES-1:0] mask_o,
   output logic [NLINES-1:0] mode_o,
   output logic              int_o
);
   logic [NLINES-1:0] mask_q, mode_q, pol_q, prev_q, latch_q;
   logic [NLINES-1:0] active, rise, clr_bits, latch_d, pend;
   logic              int_q;

   assign active   = sync_i ^ pol_q;
   assign rise     = active & ~prev_q;
   assign clr_bits = (wr_i && sel_i == RG_CLEAR) ? wdata_i : '0;
   assign latch_d  = mode_q & (rise | (latch_q & ~clr_bits));
   assign pend     = (mode_q & latch_q) | (~mode_q & active);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         mode_q  <= '0;
         pol_q   <= '0;
         prev_q  <= '0;
         latch_q <= '0;
         int_q   <= 1'b0;
      end else begin
         prev_q  <= active;
         latch_q <= latch_d;
         int_q   <= |(pend & mask_q);
         if (wr_i) begin
            case (sel_i)
               RG_MASK: mask_q <= wdata_i;
               RG_MODE: mode_q <= wdata_i;
               RG_POL:  pol_q  <= wdata_i;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (sel_i)
         RG_RAW:  rdata_o = pend;
         RG_MASK: rdata_o = mask_q;
         RG_MODE: rdata_o = mode_q;
         RG_POL:  rdata_o = pol_q;
         RG_STAT: rdata_o = pend & mask_q;
         default: rdata_o = '0;
      endcase
   end

   assign stat_o = pend & mask_q;
   assign pend_o = pend;
   assign mask_o = mask_q;
   assign mode_o = mode_q;
   assign int_o  = int_q;
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
   import intc_pkg::*;
#(
   parameter int NLINES      = 32,
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   input  logic [NLINES-1:0]   line_in,
   output logic                irq_o,
   output logic                fiq_o
);
   if (NLINES < 1 || NLINES > DW) begin : g_bad_lines
      $error("NLINES must lie in 1..DW");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NLINES-1:0]                 line_sync;
   logic [N_BANKS-1:0][NLINES-1:0]    bank_rd, bank_stat, bank_pend, bank_mask, bank_mode;
   logic [N_BANKS-1:0]                bank_int;
   logic                              aligned;
   intc_reg_e                         reg_sel;
   logic [NLINES-1:0]                 rd_sel;

   assign aligned = (bus_addr[1:0] == 2'b00);
   assign reg_sel = intc_reg_e'(bus_addr[4:2]);

   intc_line_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (line_in),
      .sync_o  (line_sync)
   );

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      intc_bank #(.NLINES(NLINES)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .sync_i  (line_sync),
         .wr_i    (bus_wr && aligned && (bus_addr[5] == 1'(b))),
         .sel_i   (reg_sel),
         .wdata_i (bus_wdata[NLINES-1:0]),
         .rdata_o (bank_rd[b]),
         .stat_o  (bank_stat[b]),
         .pend_o  (bank_pend[b]),
         .mask_o  (bank_mask[b]),
         .mode_o  (bank_mode[b]),
         .int_o   (bank_int[b])
      );
   end

   assign rd_sel = aligned ? bank_rd[bus_addr[5]] : '0;

   if (NLINES == DW) begin : g_full
      assign bus_rdata = rd_sel;
   end else begin : g_pad
      assign bus_rdata = {{(DW-NLINES){1'b0}}, rd_sel};
   end

   assign irq_o = bank_int[0];
   assign fiq_o = bank_int[1];
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
   parameter int NLINES = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [5:0]        bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              irq_o,
   input logic              fiq_o,
   input logic [NLINES-1:0] irq_stat,
   input logic [NLINES-1:0] fiq_stat,
   input logic [NLINES-1:0] irq_pend,
   input logic [NLINES-1:0] irq_mode,
   input logic [NLINES-1:0] irq_mask,
   input logic [NLINES-1:0] fiq_mask
);
   logic irq_wr, clr_or_mode_wr, mask_zero_wr;
   assign irq_wr         = bus_wr && !bus_addr[5] && bus_addr[1:0] == 2'b00;
   assign clr_or_mode_wr = irq_wr && (bus_addr[4:2] == 3'd2 || bus_addr[4:2] == 3'd3);
   assign mask_zero_wr   = irq_wr && bus_addr[4:2] == 3'd1 && bus_wdata[NLINES-1:0] == '0;

   // R10: reset holds configuration and outputs at zero
   assert_reset_clear_R10: assert property (@(posedge clk)
      !rst_n |-> (irq_mask == '0 && fiq_mask == '0 && irq_mode == '0 && !irq_o && !fiq_o));

   assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_stat) |=> irq_o);
   assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(|irq_stat) |=> !irq_o);
   assert_fiq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|fiq_stat) |=> fiq_o);

   assert_mask_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_zero_wr |=> irq_stat == '0);

   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_or_mode_wr |=>
         ((irq_pend & $past(irq_pend & irq_mode)) == $past(irq_pend & irq_mode)));

   assert_fiq_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wr |=> $stable(fiq_mask));
endmodule

bind dual_bank_intc intc_checker #(.NLINES(NLINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (32'(bus_wdata)),
   .irq_o     (irq_o),
   .fiq_o     (fiq_o),
   .irq_stat  (bank_stat[0]),
   .fiq_stat  (bank_stat[1]),
   .irq_pend  (bank_pend[0]),
   .irq_mode  (bank_mode[0]),
   .irq_mask  (bank_mask[0]),
   .fiq_mask  (bank_mask[1])
);

// File: tb/sim_dual_bank_intc.sv
module sim_dual_bank_intc;
   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] FB = 6'h20;
   localparam logic [5:0] O_RAW = 6'h00, O_MASK = 6'h04, O_CLR = 6'h08,
                          O_MODE = 6'h0C, O_POL = 6'h10, O_STAT = 6'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] line_in = '0;
   logic        irq_o, fiq_o;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_bank_intc u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [5:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, pat, s, lowest, prev_low;
      int          iters;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      for (int b = 0; b < 2; b++)
         for (int r = 0; r < 6; r++) begin
            rd(6'(b*32 + r*4), v); chk("R10 reset reg", v, 32'h0);
         end
      chk("R10 reset irq_o", 32'(irq_o), 0);
      chk("R10 reset fiq_o", 32'(fiq_o), 0);

      // R1 / R9 readback and bank independence
      wr(O_MASK, 32'h1234_5678); wr(O_MODE, 32'h0F0F_0F0F); wr(O_POL, 32'hF00D_BEEF);
      wr(FB|O_MASK, 32'hCAFE_0001); wr(O_CLR, 32'hFFFF_FFFF);
      rd(O_MASK, v); chk("R1 mask readback", v, 32'h1234_5678);
      rd(O_MODE, v); chk("R1 mode readback", v, 32'h0F0F_0F0F);
      rd(O_POL, v);  chk("R1 pol readback", v, 32'hF00D_BEEF);
      rd(O_CLR, v);  chk("R1 clear reads zero", v, 32'h0);
      rd(FB|O_MASK, v); chk("R9 fast mask separate", v, 32'hCAFE_0001);
      rd(FB|O_MODE, v); chk("R9 fast mode untouched", v, 32'h0);
      rd(FB|O_POL, v);  chk("R9 fast pol untouched", v, 32'h0);
      wr(O_MODE, 0); wr(O_POL, 0); wr(FB|O_MASK, 0);

      // R2 level high, R6 masking, R7 output
      wr(O_MASK, 32'h00FF_00FF);
      for (int k = 0; k < 4; k++) begin
         pat = 32'h9E37_79B9 * (k + 1);
         line_in = pat; settle();
         rd(O_RAW, v);  chk("R2 level high raw", v, pat);
         rd(O_STAT, v); chk("R6 status masked", v, pat & 32'h00FF_00FF);
         chk("R7 irq_o level", 32'(irq_o), 32'(|(pat & 32'h00FF_00FF)));
      end
      // R2 level low
      wr(O_POL, 32'hFFFF_FFFF);
      line_in = 32'h0000_FFFF; settle();
      rd(O_RAW, v); chk("R2 level low raw", v, 32'hFFFF_0000);
      // R5 clear on level lines has no lasting effect
      wr(O_CLR, 32'hFFFF_FFFF); @(negedge clk);
      rd(O_RAW, v); chk("R5 level survives clear", v, 32'hFFFF_0000);
      rd(O_STAT, v); chk("R5 level status", v, 32'h00FF_0000);
      wr(O_POL, 0); line_in = 0; settle();
      chk("R7 irq_o idle", 32'(irq_o), 0);

      // R3 rising edge sticky, R4 clear
      wr(O_MODE, 32'hFFFF_FFFF); wr(O_MASK, 32'hFFFF_FFFF);
      pat = 32'hA5A5_0F0F;
      line_in = pat; settle(); line_in = 0; settle();
      rd(O_RAW, v); chk("R3 rising sticky", v, pat);
      wr(O_CLR, 32'h0); @(negedge clk);
      rd(O_RAW, v); chk("R4 zero write no effect", v, pat);
      wr(O_CLR, 32'h0000_FFFF); @(negedge clk);
      rd(O_RAW, v); chk("R4 partial clear", v, pat & 32'hFFFF_0000);
      wr(O_CLR, 32'hFFFF_FFFF); @(negedge clk);
      rd(O_RAW, v); chk("R4 full clear", v, 32'h0);
      chk("R7 irq_o after clear", 32'(irq_o), 0);

      // R3 falling edge
      wr(O_MODE, 0); wr(O_POL, 32'hFFFF_FFFF); wr(O_MODE, 32'hFFFF_FFFF); settle();
      rd(O_RAW, v); chk("R3 no spurious edge", v, 32'h0);
      line_in = 32'hFFFF_FFFF; settle();
      rd(O_RAW, v); chk("R3 rising ignored when falling set", v, 32'h0);
      line_in = 32'h3C3C_3C3C; settle();
      rd(O_RAW, v); chk("R3 falling sticky", v, 32'hC3C3_C3C3);
      wr(O_MODE, 0); wr(O_POL, 0); line_in = 0; wr(O_MODE, 32'hFFFF_FFFF); settle();
      wr(O_CLR, 32'hFFFF_FFFF);

      // R4 edge coincident with clear wins
      line_in = 32'h8; settle(); line_in = 0; settle();
      rd(O_RAW, v); chk("R4 pre-set", v, 32'h8);
      line_in = 32'h8; @(negedge clk); @(negedge clk);
      wr(O_CLR, 32'h8);
      rd(O_RAW, v); chk("R4 edge beats clear", v, 32'h8);
      wr(O_CLR, 32'h8); @(negedge clk);
      rd(O_RAW, v); chk("R4 clear after", v, 32'h0);
      line_in = 0; settle();

      // R6/R7 walking sweep over every line
      for (int n = 0; n < 32; n++) begin
         line_in = 0; settle(); wr(O_CLR, 32'hFFFF_FFFF);
         wr(O_MASK, 32'h1 << n);
         line_in = 32'hFFFF_FFFF; settle();
         rd(O_STAT, v); chk("R6 walking status", v, 32'h1 << n);
         chk("R7 walking irq_o", 32'(irq_o), 1);
         wr(O_CLR, 32'h1 << n); @(negedge clk);
         chk("R7 walking irq_o cleared", 32'(irq_o), 0);
         rd(O_RAW, v); chk("R4 walking others kept", v, ~(32'h1 << n));
      end

      // R8 lowest-bit service loop
      line_in = 0; settle(); wr(O_CLR, 32'hFFFF_FFFF); wr(O_MASK, 32'hFFFF_FFFF);
      pat = 32'hA500_0C31;
      line_in = pat; settle(); line_in = 0; settle();
      iters = 0; prev_low = 0;
      for (int g = 0; g < 40; g++) begin
         rd(O_STAT, s);
         if (s == 0) break;
         lowest = s & (~s + 1);
         chk("R8 ascending order", 32'(lowest > prev_low), 1);
         prev_low = lowest;
         wr(O_CLR, lowest); iters++;
      end
      chk("R8 iteration count", 32'(iters), 32'($countones(pat)));

      // R9 fast bank drives only its own output
      wr(O_MASK, 0); wr(O_MODE, 0);
      wr(FB|O_MASK, 32'h0000_FF00);
      line_in = 32'h0000_0100; settle();
      rd(FB|O_STAT, v); chk("R9 fast status", v, 32'h100);
      chk("R9 fiq_o set", 32'(fiq_o), 1);
      chk("R9 irq_o stays low", 32'(irq_o), 0);
      rd(O_STAT, v); chk("R9 normal status zero", v, 32'h0);
      wr(O_MASK, 32'hFFFF_FFFF); @(negedge clk);
      chk("R9 irq_o follows own bank", 32'(irq_o), 1);
      rd(FB|O_MASK, v); chk("R9 fast mask kept", v, 32'h0000_FF00);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule